// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block picks which interrupt a small in-order microcontroller core should service next. It watches a set of level-sensitive peripheral request lines, one software-only context-switch source and one non-maskable input. Each maskable source carries a programmable priority and an enable bit. A source is offered to the core only when its priority is above both a programmable threshold and the priority of the handler that is running now. A running handler can therefore be preempted by a more urgent one, and the controller keeps a stack of the priorities it has preempted.

The request is presented as a vector-table entry address, formed from a programmable table base plus the winning source index times the pointer size in bytes. The core accepts the request with a one-cycle acknowledge, which clears that source's pending flag and raises the active priority. It signals the end of a handler with a one-cycle return strobe, which restores the priority that was active before. The non-maskable input is edge-detected. It is taken regardless of enables and threshold, nothing maskable can interrupt it, and its return resumes the preempted handler at that handler's priority. All control state sits behind a simple word-addressed register bus.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous reset all enables, pending flags, threshold, vector base and active priority read as zero, and no request is offered.
- R2: A maskable source is offered only when its priority is strictly greater than the threshold register (word 3, bits [PRIO_W-1:0]).
- R3: A maskable source is offered only when its priority is strictly greater than the active priority (readable at word 5). Accepting it pushes the old active priority and makes the source's priority active.
- R4: Among offered candidates the highest priority wins; on equal priority the lowest source index wins.
- R5: The request address equals the vector base (word 4) plus the winning index times PTR_BYTES. The non-maskable source uses index NUM_SRC.
- R6: Source NUM_SRC-1 is the context-switch source, with a priority fixed at 1. Writes to its priority word are ignored. It has no input line and becomes pending only when bit NUM_SRC-1 is written as 1 to the software-set word (word 2).
- R7: Accepting a maskable source clears its pending flag (word 1, bit = source index). A source whose line is still high is pending again one cycle later.
- R8: A return strobe pops the stack and restores the previously active priority. Nested handlers unwind in reverse order.
- R9: A rising edge on the non-maskable input is offered ahead of every maskable source, ignoring enables and threshold. While it is active no maskable source is offered. Its return leaves the active priority unchanged.
- R10: Enable (word 0, bit per source), threshold, vector base and source priorities (word 8+index) read back the values written.
- R11: A source whose enable bit is 0 stays pending but is never offered. Setting the bit lets it be offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_SRC-1 | Level-sensitive peripheral request lines, one per source 0..NUM_SRC-2 |
| nmi_i | input | 1 | Non-maskable request, rising-edge detected |
| bus_en_i | input | 1 | Register bus access strobe |
| bus_we_i | input | 1 | Register bus write (1) or read (0) |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data, combinational from address |
| req_valid_o | output | 1 | A source is offered to the core |
| req_addr_o | output | DATA_W | Vector-table entry address of the offered source |
| ack_i | input | 1 | Core accepts the offered source this cycle |
| ret_i | input | 1 | Core returns from the current handler this cycle |

## Verification
A behavioural reference model in the bench tracks pending flags, a queue of preempted priorities and the non-maskable state, and it is compared with the request outputs on every cycle. Stimulus first raises a single source to confirm the address arithmetic. It then raises a lower-priority source under a running handler to show that preemption needs a strictly higher priority, and raises two equal-priority sources together to show the index tie-break. Threshold steps of 2 and 1 around a priority-2 source separate the strict comparison from a non-strict one. The non-maskable pulse is sent with all enables cleared and the threshold at maximum, and a higher-priority line is raised while it runs, so that masking, blocking and the resume of the preempted priority can each be observed.

// File: rtl/irq_nest_pkg.sv
// Shared constants for the nested interrupt controller: register word
// addresses and the fixed priority of the context-switch source.
// Assumes a word-addressed register bus of at least 5 address bits.
package irq_nest_pkg;
    localparam int A_ENABLE   = 0;  // per-source enable bits
    localparam int A_PENDING  = 1;  // pending flags (read only)
    localparam int A_SWSET    = 2;  // write 1 to set pending (write only)
    localparam int A_THRESH   = 3;  // priority threshold
    localparam int A_VBASE    = 4;  // vector table base address
    localparam int A_ACTIVE   = 5;  // active priority (read only)
    localparam int A_PRIO0    = 8;  // priority of source i at A_PRIO0+i
    localparam int CS_PRIO    = 1;  // fixed lowest takeable priority
endpackage

// File: rtl/irq_regs.sv
// Memory-mapped register file and pending flags.
// Holds enables, threshold, vector base and per-source priorities; the
// last source is the context-switch source with a fixed priority and no
// input line. Pending flags are set by high lines or software writes and
// cleared by the acknowledge vector; a set in the same cycle wins.
module irq_regs
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en_i,
    input  logic                      bus_we_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    input  logic [NUM_SRC-2:0]        irq_i,
    input  logic [NUM_SRC-1:0]        clr_i,
    input  logic [PRIO_W-1:0]         active_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [NUM_SRC-1:0]        enable_o,
    output logic [NUM_SRC-1:0]        pending_o,
    output logic [PRIO_W-1:0]         thresh_o,
    output logic [DATA_W-1:0]         vbase_o,
    output logic [NUM_SRC*PRIO_W-1:0] prio_o
);
    localparam int CS_IDX = NUM_SRC - 1;

    logic                wr;
    logic [NUM_SRC-1:0]  swset;
    logic [NUM_SRC-1:0]  set_vec;
    logic [NUM_SRC-1:0]  enable_q;
    logic [NUM_SRC-1:0]  pending_q;
    logic [PRIO_W-1:0]   thresh_q;
    logic [DATA_W-1:0]   vbase_q;
    logic [PRIO_W-1:0]   prio_q [NUM_SRC];

    // Decode a write strobe and the software-set vector.
    always_comb begin
        wr    = bus_en_i & bus_we_i;
        swset = (wr && bus_addr_i == ADDR_W'(A_SWSET)) ? bus_wdata_i[NUM_SRC-1:0] : '0;
        set_vec = {1'b0, irq_i} | swset;
    end

    // Enable, threshold and vector base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            thresh_q <= '0;
            vbase_q  <= '0;
        end else if (wr) begin
            if (bus_addr_i == ADDR_W'(A_ENABLE)) enable_q <= bus_wdata_i[NUM_SRC-1:0];
            if (bus_addr_i == ADDR_W'(A_THRESH)) thresh_q <= bus_wdata_i[PRIO_W-1:0];
            if (bus_addr_i == ADDR_W'(A_VBASE))  vbase_q  <= bus_wdata_i;
        end
    end

    // Pending flags: set by lines or software, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clr_i) | set_vec;
    end

    // Per-source priority registers; the context-switch one is fixed.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        if (i == CS_IDX) begin : g_cs
            // Fixed priority, no write path.
            always_ff @(posedge clk) begin
                prio_q[i] <= PRIO_W'(CS_PRIO);
            end
        end else begin : g_norm
            // Writable priority for a peripheral source.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_q[i] <= '0;
                else if (wr && bus_addr_i == ADDR_W'(A_PRIO0 + i))
                    prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
            end
        end
        assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // Read mux over control words and priority words.
    always_comb begin
        rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_ENABLE):  rdata_o = DATA_W'(enable_q);
            ADDR_W'(A_PENDING): rdata_o = DATA_W'(pending_q);
            ADDR_W'(A_THRESH):  rdata_o = DATA_W'(thresh_q);
            ADDR_W'(A_VBASE):   rdata_o = vbase_q;
            ADDR_W'(A_ACTIVE):  rdata_o = DATA_W'(active_i);
            default:            rdata_o = '0;
        endcase
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr_i == ADDR_W'(A_PRIO0 + i)) rdata_o = DATA_W'(prio_q[i]);
        end
    end

    assign enable_o  = enable_q;
    assign pending_o = pending_q;
    assign thresh_o  = thresh_q;
    assign vbase_o   = vbase_q;

    // R7: an acknowledged flag with no new set is clear next cycle.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) && ((clr_i & set_vec) == '0) |=> ((pending_q & $past(clr_i)) == '0));

    // R7: a high line is pending on the following cycle.
    p_level_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i != '0) |=> ((pending_q[NUM_SRC-2:0] & $past(irq_i)) == $past(irq_i)));

    // R6: software set of the context-switch source makes it pending.
    p_cs_swset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swset[CS_IDX] |=> pending_o[CS_IDX]);
endmodule

// File: rtl/irq_pick.sv
// Combinational arbiter. Chooses the non-maskable request when it is
// pending and not already running; otherwise the highest-priority
// pending, enabled maskable source above both threshold and active
// priority, lowest index on ties. Maskable sources are blocked while the
// non-maskable handler runs. Clock and reset only feed the assertions.
module irq_pick #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        pending_i,
    input  logic [NUM_SRC-1:0]        enable_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    input  logic [PRIO_W-1:0]         active_i,
    input  logic                      nmi_pend_i,
    input  logic                      nmi_act_i,
    output logic                      valid_o,
    output logic                      is_nmi_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  bidx;
    logic [PRIO_W-1:0] p;

    // Scan sources upward; strict compare keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        best  = '0;
        bidx  = '0;
        p     = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            p = prio_i[i*PRIO_W +: PRIO_W];
            if (pending_i[i] && enable_i[i] && p > thresh_i && p > active_i
                && (!found || p > best)) begin
                found = 1'b1;
                best  = p;
                bidx  = IDX_W'(i);
            end
        end
    end

    // Non-maskable request overrides; maskable ones wait while it runs.
    always_comb begin
        is_nmi_o = nmi_pend_i & ~nmi_act_i;
        valid_o  = is_nmi_o | (found & ~nmi_act_i);
        idx_o    = is_nmi_o ? IDX_W'(NUM_SRC) : bidx;
        prio_o   = best;
    end

    // R2: an offered maskable source is above the threshold.
    p_above_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !is_nmi_o |-> prio_o > thresh_i);

    // R11: an offered maskable source is pending and enabled.
    p_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !is_nmi_o |-> (pending_i[idx_o] && enable_i[idx_o]));

    // R9: nothing maskable is offered while the non-maskable handler runs.
    p_nmi_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_act_i |-> !(valid_o && !is_nmi_o));
endmodule

// File: rtl/irq_active_stack.sv
// Active-priority tracker. Holds the running priority, a stack of
// preempted priorities (one slot per level, enough because each push is
// strictly higher), and the non-maskable pending/running flags. A return
// ends the non-maskable handler first if it runs, else pops the stack.
// Assumes take_i is never high together with ret_i.
module irq_active_stack #(
    parameter int NLVL   = 8,
    parameter int PRIO_W = 3,
    localparam int SW    = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              take_nmi_i,
    input  logic [PRIO_W-1:0] take_prio_i,
    input  logic              ret_i,
    input  logic              nmi_i,
    output logic [PRIO_W-1:0] active_o,
    output logic              nmi_pend_o,
    output logic              nmi_act_o
);
    logic [PRIO_W-1:0] stk_q [NLVL];
    logic [SW-1:0]     depth_q;
    logic [PRIO_W-1:0] active_q;
    logic              nmi_prev_q;
    logic              nmi_pend_q;
    logic              nmi_act_q;

    // Push on maskable take, pop on return, track non-maskable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NLVL; k++) stk_q[k] <= '0;
            depth_q    <= '0;
            active_q   <= '0;
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
            nmi_act_q  <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= (nmi_i & ~nmi_prev_q) | (nmi_pend_q & ~(take_i & take_nmi_i));
            if (ret_i) begin
                if (nmi_act_q) begin
                    nmi_act_q <= 1'b0;
                end else if (depth_q != '0) begin
                    depth_q  <= depth_q - 1'b1;
                    active_q <= stk_q[depth_q - 1'b1];
                end
            end else if (take_i) begin
                if (take_nmi_i) begin
                    nmi_act_q <= 1'b1;
                end else begin
                    stk_q[depth_q] <= active_q;
                    depth_q        <= depth_q + 1'b1;
                    active_q       <= take_prio_i;
                end
            end
        end
    end

    assign active_o   = active_q;
    assign nmi_pend_o = nmi_pend_q;
    assign nmi_act_o  = nmi_act_q;

    // R3: a maskable take always raises the active priority.
    p_take_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !take_nmi_i |=> active_q > $past(active_q));

    // R8: a return outside the non-maskable handler pops one level.
    p_ret_pops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && !nmi_act_q && depth_q != '0 |=> depth_q == $past(depth_q) - 1'b1);

    // R8: the stack never needs more slots than there are levels.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !take_nmi_i |-> depth_q != SW'(NLVL - 1));

    // R9: leaving the non-maskable handler keeps the preempted priority.
    p_nmi_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && nmi_act_q |=> active_q == $past(active_q) && !nmi_act_q);
endmodule

// File: rtl/irq_nest_ctrl.sv
// Top of the nested vectored interrupt controller. Connects the register
// file, the arbiter and the active-priority stack, qualifies the core's
// acknowledge (ignored when nothing is offered or a return is signalled
// in the same cycle) and forms the vector-table entry address.
module irq_nest_ctrl #(
    parameter int NUM_SRC   = 8,
    parameter int NLVL      = 8,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int PTR_BYTES = 4,
    localparam int PRIO_W   = (NLVL > 1) ? $clog2(NLVL) : 1,
    localparam int IDX_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-2:0] irq_i,
    input  logic               nmi_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               req_valid_o,
    output logic [DATA_W-1:0]  req_addr_o,
    input  logic               ack_i,
    input  logic               ret_i
);
    logic [NUM_SRC-1:0]        enable;
    logic [NUM_SRC-1:0]        pending;
    logic [PRIO_W-1:0]         thresh;
    logic [DATA_W-1:0]         vbase;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]         active;
    logic                      nmi_pend;
    logic                      nmi_act;
    logic                      pick_valid;
    logic                      pick_nmi;
    logic [IDX_W-1:0]          pick_idx;
    logic [PRIO_W-1:0]         pick_prio;
    logic                      take;
    logic [NUM_SRC-1:0]        clr_vec;

    irq_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .irq_i(irq_i), .clr_i(clr_vec), .active_i(active),
        .rdata_o(bus_rdata_o), .enable_o(enable), .pending_o(pending),
        .thresh_o(thresh), .vbase_o(vbase), .prio_o(prio_flat)
    );

    irq_pick #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pending_i(pending), .enable_i(enable), .prio_i(prio_flat),
        .thresh_i(thresh), .active_i(active),
        .nmi_pend_i(nmi_pend), .nmi_act_i(nmi_act),
        .valid_o(pick_valid), .is_nmi_o(pick_nmi),
        .idx_o(pick_idx), .prio_o(pick_prio)
    );

    irq_active_stack #(
        .NLVL(NLVL), .PRIO_W(PRIO_W)
    ) u_stack (
        .clk(clk), .rst_n(rst_n),
        .take_i(take), .take_nmi_i(pick_nmi), .take_prio_i(pick_prio),
        .ret_i(ret_i), .nmi_i(nmi_i),
        .active_o(active), .nmi_pend_o(nmi_pend), .nmi_act_o(nmi_act)
    );

    // Qualify the acknowledge and build the one-hot clear vector.
    always_comb begin
        take    = ack_i & pick_valid & ~ret_i;
        clr_vec = (take && !pick_nmi) ? (NUM_SRC'(1) << pick_idx) : '0;
    end

    // Vector entry address: table base plus index times pointer size.
    always_comb begin
        req_valid_o = pick_valid;
        req_addr_o  = vbase + DATA_W'(pick_idx) * DATA_W'(PTR_BYTES);
    end
endmodule

// File: tb/irq_nest_ctrl_bench.sv
// Self-checking bench: a behavioural model (arrays and a queue of
// preempted priorities) runs beside the design and is compared on every
// negative clock edge; directed checks cover each requirement.
module irq_nest_ctrl_bench;
    localparam int NS = 8;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int PB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-2:0] irq = '0;
    logic          nmi = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          req_valid;
    logic [DW-1:0] req_addr;
    logic          ack = 1'b0, ret = 1'b0;

    always #5 clk = ~clk;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .req_valid_o(req_valid), .req_addr_o(req_addr),
        .ack_i(ack), .ret_i(ret)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit model_live = 0;

    // Reference model state
    int m_en[NS], m_pend[NS], m_prio[NS];
    int m_thr, m_base, m_act;
    int m_stk[$];
    bit m_nmi_pend, m_nmi_act, m_nmi_prev;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void m_pick(output bit v, output int idx, output int pr, output bit isn);
        v = 0; idx = 0; pr = 0; isn = 0;
        if (m_nmi_pend && !m_nmi_act) begin
            v = 1; isn = 1; idx = NS;
        end else if (!m_nmi_act) begin
            for (int i = 0; i < NS; i++)
                if (m_pend[i] != 0 && m_en[i] != 0 && m_prio[i] > m_thr
                    && m_prio[i] > m_act && (!v || m_prio[i] > pr)) begin
                    v = 1; pr = m_prio[i]; idx = i;
                end
        end
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        bit v, isn; int idx, pr;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_pend[i] = 0; m_prio[i] = 0; end
            m_prio[NS-1] = 1;
            m_thr = 0; m_base = 0; m_act = 0; m_stk.delete();
            m_nmi_pend = 0; m_nmi_act = 0; m_nmi_prev = 0;
        end else begin
            m_pick(v, idx, pr, isn);
            if (ret) begin
                if (m_nmi_act) m_nmi_act = 0;
                else if (m_stk.size() > 0) m_act = m_stk.pop_back();
            end else if (ack && v) begin
                if (isn) begin m_nmi_act = 1; m_nmi_pend = 0; end
                else begin m_stk.push_back(m_act); m_act = pr; m_pend[idx] = 0; end
            end
            if (nmi && !m_nmi_prev) m_nmi_pend = 1;
            m_nmi_prev = nmi;
            for (int i = 0; i < NS-1; i++) if (irq[i]) m_pend[i] = 1;
            if (bus_en && bus_we) begin
                case (int'(bus_addr))
                    0: for (int i = 0; i < NS; i++) m_en[i] = int'(bus_wdata[i]);
                    2: for (int i = 0; i < NS; i++) if (bus_wdata[i]) m_pend[i] = 1;
                    3: m_thr = int'(bus_wdata[2:0]);
                    4: m_base = int'(bus_wdata);
                    default: if (int'(bus_addr) >= 8 && int'(bus_addr) < 8+NS-1)
                                 m_prio[int'(bus_addr)-8] = int'(bus_wdata[2:0]);
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison of the request outputs.
    always @(negedge clk) begin
        bit v, isn; int idx, pr;
        if (model_live) begin
            m_pick(v, idx, pr, isn);
            check(req_valid == v, "R2 R3 R4 R9 R11 model valid", DW'(req_valid), DW'(v));
            if (v) check(req_addr == DW'(m_base + idx*PB), "R5 model address", req_addr, DW'(m_base + idx*PB));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected<=20000", cyc);
            report();
        end
    end

    task automatic step(); @(posedge clk); #2; endtask

    task automatic wr(int a, int d);
        step(); bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
        step(); bus_en = 0; bus_we = 0;
    endtask

    task automatic rd_chk(int a, int exp, string tag);
        step(); bus_en = 1; bus_we = 0; bus_addr = AW'(a); #1;
        check(bus_rdata == DW'(exp), tag, bus_rdata, DW'(exp));
        bus_en = 0;
    endtask

    task automatic req_chk(bit v, int addr, string tag);
        step();
        check(req_valid == v, tag, DW'(req_valid), DW'(v));
        if (v) check(req_addr == DW'(addr), tag, req_addr, DW'(addr));
    endtask

    task automatic do_ack(logic [NS-2:0] drop);
        step(); ack = 1; irq = irq & ~drop;
        step(); ack = 0;
    endtask

    task automatic do_ret();
        step(); ret = 1;
        step(); ret = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        model_live = 1;
        // R1: reset state
        rd_chk(0, 0, "R1 enable after reset");
        rd_chk(3, 0, "R1 threshold after reset");
        rd_chk(5, 0, "R1 active after reset");
        check(req_valid == 1'b0, "R1 no request after reset", DW'(req_valid), 0);
        // R10 / R6: configuration
        wr(4, 'h1000); wr(8, 3); wr(9, 5); wr(10, 5); wr(11, 2); wr(12, 6); wr(15, 7);
        rd_chk(15, 1, "R6 context-switch priority fixed");
        rd_chk(9, 5, "R10 priority readback");
        rd_chk(4, 'h1000, "R10 base readback");
        wr(0, 'hFF);
        rd_chk(0, 'hFF, "R10 enable readback");
        // R5: single source
        irq[0] = 1;
        req_chk(1, 'h1000, "R5 source 0 vector");
        do_ack(7'h01);
        rd_chk(1, 0, "R7 pending cleared on accept");
        rd_chk(5, 3, "R3 active raised to 3");
        // R3: lower priority does not preempt
        irq[3] = 1;
        req_chk(0, 0, "R3 lower priority held back");
        // R4: equal-priority tie
        irq[1] = 1; irq[2] = 1;
        req_chk(1, 'h1004, "R4 lowest index wins tie");
        do_ack(7'h0E);
        req_chk(0, 0, "R3 equal priority no preempt");
        // R8: unwinding
        do_ret();
        rd_chk(5, 3, "R8 active restored to 3");
        req_chk(1, 'h1008, "R8 source 2 after return");
        do_ack(7'h00);
        do_ret(); do_ret();
        rd_chk(5, 0, "R8 fully unwound");
        // R2: threshold strictness
        wr(3, 2);
        req_chk(0, 0, "R2 priority equal to threshold");
        wr(3, 1);
        req_chk(1, 'h100C, "R2 priority above threshold");
        do_ack(7'h00); do_ret();
        // R11: enable gating
        wr(0, 'hEF);
        irq[4] = 1;
        req_chk(0, 0, "R11 disabled source not offered");
        rd_chk(1, 'h10, "R11 disabled source still pending");
        wr(0, 'hFF);
        req_chk(1, 'h1010, "R11 enabled source offered");
        do_ack(7'h10);
        // R9: non-maskable
        wr(0, 0); wr(3, 7);
        nmi = 1;
        req_chk(1, 'h1020, "R9 non-maskable ignores masks");
        do_ack(7'h00);
        nmi = 0;
        wr(0, 'hFF); wr(3, 0); wr(9, 7);
        irq[1] = 1;
        req_chk(0, 0, "R9 maskable blocked during non-maskable");
        do_ret();
        rd_chk(5, 6, "R9 preempted priority resumed");
        req_chk(1, 'h1004, "R9 maskable offered after return");
        do_ack(7'h02);
        do_ret(); do_ret();
        rd_chk(5, 0, "R8 unwound after nesting");
        // R7: level still high re-pends
        irq[0] = 1;
        req_chk(1, 'h1000, "R7 source 0 offered");
        do_ack(7'h00);
        rd_chk(1, 1, "R7 level re-sets pending");
        irq[0] = 0;
        do_ret();
        do_ack(7'h00); do_ret();
        // R6: software-set context switch
        wr(2, 'h80);
        req_chk(1, 'h101C, "R6 context switch offered");
        do_ack(7'h00);
        rd_chk(5, 1, "R6 context switch at priority 1");
        do_ret();
        repeat (3) step();
        report();
    end
endmodule